// File: doc/BRIEF.md
# Debounced Pitch Step Controller

This block keeps the current pitch step (0 to 16) of a voice pitch shifter. Step 8 is the neutral setting, where the pitch is not changed. The controls come from mechanical switches, so every control line is synchronised and then filtered for chatter before it is used. The filter is asymmetric. A line must hold a new high level for `HOLD_CYC` clock cycles before the block accepts it. It must hold a new low level for `GAP_CYC` cycles before a later press counts as a separate press.

A filtered mode line selects how the step is set.

- **Counting mode:** separate increment, decrement and centre-request buttons move the step. The step saturates at both ends.
- **Direct mode:** a 4-bit filtered code loads the step directly, so steps 0 to 15 can be reached.

The block drives the step value and a one-cycle strobe that marks each change of the step. A power-down input freezes all sampling and state. A synchronous reset returns the step to the centre value.

Top module: `pitch_step_ctrl`

## Requirements
- R1: While `rst_i` is high at a clock edge, the step becomes 8 and `step_chg_o` becomes 0.
- R2: In counting mode (`mode_i` filtered low), each accepted press of `inc_i` raises the step by one. A press held for any length gives exactly one change.
- R3: In counting mode, each accepted press of `dec_i` lowers the step by one.
- R4: The step saturates. An increment at 16 leaves 16, and a decrement at 0 leaves 0. Neither produces a strobe.
- R5: In counting mode, a filtered-high `ctr_i` holds the step at 8. A press of `inc_i` or `dec_i` while the other line is also filtered high (including both in the same cycle) sets the step to 8.
- R6: In direct mode (`mode_i` filtered high), the step equals the filtered `code_i` value, with bit 3 as the MSB, giving 0 to 15. In this mode `inc_i`, `dec_i` and `ctr_i` have no effect. In counting mode, `code_i` has no effect.
- R7: A line level held for fewer than `HOLD_CYC` cycles is not accepted. A low gap shorter than `GAP_CYC` cycles between two highs does not split them into two presses.
- R8: While `pwr_dn_i` is high, no input is sampled, and the step and the filter state hold their values.
- R9: `step_chg_o` is high for exactly the one cycle after each edge at which the step value changed, and low otherwise.
- R10: The step never exceeds 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| pwr_dn_i | input | 1 | Power-down; freezes all sampling and state |
| mode_i | input | 1 | Mode select: 0 = counting, 1 = direct (filtered) |
| inc_i | input | 1 | Increment button |
| dec_i | input | 1 | Decrement button |
| ctr_i | input | 1 | Centre-request button |
| code_i | input | 4 | Direct step code, bit 3 is the MSB |
| step_o | output | 5 | Current pitch step, 0 to 16 |
| step_chg_o | output | 1 | One-cycle strobe after the step changes |

## Verification
The bench builds the block with `HOLD_CYC` = 8 and `GAP_CYC` = 4 instead of the millisecond-scale defaults. At these values a full press and release takes a few dozen cycles. This puts both saturation walks within a short run, along with the short-glitch and short-gap filter cases and the held-button case. The strobe count is kept by a monitor, so every press is also checked for producing exactly zero or one change.

// File: rtl/pitch_pkg.sv
package pitch_pkg;
  localparam int STEP_W   = 5;
  localparam int STEP_TOP = 16;
  localparam int STEP_MID = 8;
  localparam int CODE_W   = 4;

  typedef logic [STEP_W-1:0] step_t;

  // saturating increment
  function automatic step_t f_step_inc(input step_t s);
    return (s >= step_t'(STEP_TOP)) ? step_t'(STEP_TOP) : s + step_t'(1);
  endfunction

  // saturating decrement
  function automatic step_t f_step_dec(input step_t s);
    return (s == '0) ? '0 : s - step_t'(1);
  endfunction
endpackage

// File: rtl/pitch_debounce.sv
module pitch_debounce #(
  parameter int HOLD_CYC = 8,
  parameter int GAP_CYC  = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic raw_i,
  output logic lvl_o
);
  localparam int MAXC = (HOLD_CYC > GAP_CYC) ? HOLD_CYC : GAP_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] HOLD_END = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] GAP_END  = CW'(GAP_CYC - 1);

  logic          s1_q, s2_q, lvl_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] end_w;

  // a rising change needs the hold window, a falling one the gap window
  assign end_w = lvl_q ? GAP_END : HOLD_END;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (en_i) begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      if (s2_q == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q == end_w) begin
        lvl_q <= s2_q;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/pitch_step_core.sv
module pitch_step_core
  import pitch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              en_i,
  input  logic              mode_lvl_i,
  input  logic              inc_lvl_i,
  input  logic              dec_lvl_i,
  input  logic              ctr_lvl_i,
  input  logic [CODE_W-1:0] code_lvl_i,
  output logic              inc_rise_o,
  output logic              dec_rise_o,
  output step_t             step_o,
  output logic              chg_o
);
  logic  inc_d_q, dec_d_q;
  step_t step_q, step_nx;
  logic  chg_q;

  assign inc_rise_o = inc_lvl_i & ~inc_d_q;
  assign dec_rise_o = dec_lvl_i & ~dec_d_q;

  always_comb begin
    step_nx = step_q;
    if (en_i) begin
      if (mode_lvl_i)
        step_nx = step_t'(code_lvl_i);
      else if (ctr_lvl_i)
        step_nx = step_t'(STEP_MID);
      else if ((inc_rise_o && dec_lvl_i) || (dec_rise_o && inc_lvl_i))
        step_nx = step_t'(STEP_MID);
      else if (inc_rise_o)
        step_nx = f_step_inc(step_q);
      else if (dec_rise_o)
        step_nx = f_step_dec(step_q);
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      inc_d_q <= 1'b0;
      dec_d_q <= 1'b0;
      step_q  <= step_t'(STEP_MID);
      chg_q   <= 1'b0;
    end else begin
      if (en_i) begin
        inc_d_q <= inc_lvl_i;
        dec_d_q <= dec_lvl_i;
      end
      step_q <= step_nx;
      chg_q  <= (step_nx != step_q);
    end
  end

  assign step_o = step_q;
  assign chg_o  = chg_q;
endmodule

// File: rtl/pitch_step_ctrl.sv
module pitch_step_ctrl
  import pitch_pkg::*;
#(
  parameter int HOLD_CYC = 248000,
  parameter int GAP_CYC  = 124000
) (
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic        pwr_dn_i,
  input  logic        mode_i,
  input  logic        inc_i,
  input  logic        dec_i,
  input  logic        ctr_i,
  input  logic [3:0]  code_i,
  output logic [4:0]  step_o,
  output logic        step_chg_o
);
  localparam int NLINES = CODE_W + 4;

  logic              en_w;
  logic [NLINES-1:0] raw_w, lvl_w;
  logic              mode_lvl, inc_lvl, dec_lvl, ctr_lvl;
  logic [CODE_W-1:0] code_lvl;
  logic              inc_rise, dec_rise;

  assign en_w  = ~pwr_dn_i;
  assign raw_w = {code_i, mode_i, ctr_i, dec_i, inc_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    pitch_debounce #(.HOLD_CYC(HOLD_CYC), .GAP_CYC(GAP_CYC)) u_db (
      .clk_i(clk_i), .rst_i(rst_i), .en_i(en_w),
      .raw_i(raw_w[g]), .lvl_o(lvl_w[g])
    );
  end

  assign inc_lvl  = lvl_w[0];
  assign dec_lvl  = lvl_w[1];
  assign ctr_lvl  = lvl_w[2];
  assign mode_lvl = lvl_w[3];
  assign code_lvl = lvl_w[NLINES-1:4];

  pitch_step_core u_core (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(en_w),
    .mode_lvl_i(mode_lvl), .inc_lvl_i(inc_lvl), .dec_lvl_i(dec_lvl),
    .ctr_lvl_i(ctr_lvl), .code_lvl_i(code_lvl),
    .inc_rise_o(inc_rise), .dec_rise_o(dec_rise),
    .step_o(step_o), .chg_o(step_chg_o)
  );
endmodule

// File: rtl/pitch_step_chk.sv
module pitch_step_chk (
  input logic       clk_i,
  input logic       rst_i,
  input logic       pwr_dn_i,
  input logic       mode_lvl,
  input logic       inc_lvl,
  input logic       dec_lvl,
  input logic       ctr_lvl,
  input logic [3:0] code_lvl,
  input logic       inc_rise,
  input logic       dec_rise,
  input logic [4:0] step_o,
  input logic       step_chg_o
);
  p_range_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    step_o <= 5'd16);

  p_strobe_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> (step_chg_o == (step_o != $past(step_o))));

  p_freeze_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) && $past(pwr_dn_i) |-> $stable(step_o));

  p_inc_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) && $past(!pwr_dn_i && !mode_lvl && !ctr_lvl && inc_rise && !dec_lvl)
    |-> step_o == (($past(step_o) == 5'd16) ? 5'd16 : $past(step_o) + 5'd1));

  p_centre_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(!pwr_dn_i && !mode_lvl && ctr_lvl) |-> step_o == 5'd8);

  p_direct_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) && $past(!pwr_dn_i && mode_lvl) |-> step_o == {1'b0, $past(code_lvl)});

  p_dec_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) && $past(!pwr_dn_i && !mode_lvl && !ctr_lvl && dec_rise && !inc_lvl)
    |-> step_o == (($past(step_o) == 5'd0) ? 5'd0 : $past(step_o) - 5'd1));
endmodule

bind pitch_step_ctrl pitch_step_chk u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .pwr_dn_i(pwr_dn_i),
  .mode_lvl(mode_lvl), .inc_lvl(inc_lvl), .dec_lvl(dec_lvl),
  .ctr_lvl(ctr_lvl), .code_lvl(code_lvl),
  .inc_rise(inc_rise), .dec_rise(dec_rise),
  .step_o(step_o), .step_chg_o(step_chg_o)
);

// File: tb/sim_pitch_step_ctrl.sv
module sim_pitch_step_ctrl;
  localparam int HOLD = 8;
  localparam int GAP  = 4;
  localparam int WD_LIMIT = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1, pd = 1'b0, mode = 1'b0, inc = 1'b0, dec = 1'b0, ctr = 1'b0;
  logic [3:0] code = 4'd0;
  logic [4:0] step;
  logic       chg;

  int checks = 0, errors = 0, nchg = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pitch_step_ctrl #(.HOLD_CYC(HOLD), .GAP_CYC(GAP)) u0 (
    .clk_i(clk), .rst_i(rst), .pwr_dn_i(pd), .mode_i(mode),
    .inc_i(inc), .dec_i(dec), .ctr_i(ctr), .code_i(code),
    .step_o(step), .step_chg_o(chg)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (chg) nchg <= nchg + 1;
    if (cyc > WD_LIMIT && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected below %0d", cyc, WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // bits: inc, dec, ctr held then released
  task automatic press(input logic [2:0] btn);
    {inc, dec, ctr} = btn;
    wait_cyc(HOLD + 6);
    {inc, dec, ctr} = 3'b000;
    wait_cyc(GAP + 6);
  endtask

  // press then check step and number of strobes
  task automatic press_chk(input logic [2:0] btn, input int exp_step,
                           input int exp_chg, input string req);
    int c0;
    c0 = nchg;
    press(btn);
    chk(req, step, exp_step);
    chk({req, " strobe count"}, nchg - c0, exp_chg);
  endtask

  // {inc,dec,ctr, expected step[4:0], expected strobes[1:0]}
  localparam int NV = 11;
  localparam logic [9:0] VEC [NV] = '{
    {3'b100, 5'd9,  2'd1},
    {3'b100, 5'd10, 2'd1},
    {3'b100, 5'd11, 2'd1},
    {3'b010, 5'd10, 2'd1},
    {3'b110, 5'd8,  2'd1},
    {3'b010, 5'd7,  2'd1},
    {3'b010, 5'd6,  2'd1},
    {3'b001, 5'd8,  2'd1},
    {3'b001, 5'd8,  2'd0},
    {3'b100, 5'd9,  2'd1},
    {3'b110, 5'd8,  2'd1}
  };

  initial begin
    int c0;
    wait_cyc(3);
    chk("R1 reset step", step, 8);
    chk("R1 reset strobe", chg, 0);
    rst = 1'b0;
    wait_cyc(2);

    // table walk: R2 R3 R5 R9
    for (int i = 0; i < NV; i++)
      press_chk(VEC[i][9:7], VEC[i][6:2], VEC[i][1:0], "R2/R3/R5 table");

    // R4 saturation top
    for (int i = 0; i < 8; i++) press(3'b100);
    chk("R4 reach top", step, 16);
    press_chk(3'b100, 16, 0, "R4 inc at 16");
    press_chk(3'b001, 8, 1, "R5 centre");
    for (int i = 0; i < 8; i++) press(3'b010);
    chk("R4 reach bottom", step, 0);
    press_chk(3'b010, 0, 0, "R4 dec at 0");
    press_chk(3'b100, 1, 1, "R2 inc from 0");

    // R7 short glitch ignored
    c0 = nchg;
    inc = 1'b1; wait_cyc(HOLD - 3); inc = 1'b0; wait_cyc(GAP + 6);
    chk("R7 glitch step", step, 1);
    chk("R7 glitch strobe", nchg - c0, 0);

    // R7 short gap merges two highs
    c0 = nchg;
    inc = 1'b1; wait_cyc(HOLD + 6);
    inc = 1'b0; wait_cyc(GAP - 2);
    inc = 1'b1; wait_cyc(HOLD + 6);
    inc = 1'b0; wait_cyc(GAP + 6);
    chk("R7 short gap step", step, 2);
    chk("R7 short gap strobe", nchg - c0, 1);

    // R2 long hold gives one step
    c0 = nchg;
    inc = 1'b1; wait_cyc(3 * HOLD + 10); inc = 1'b0; wait_cyc(GAP + 6);
    chk("R2 held step", step, 3);
    chk("R2 held strobe", nchg - c0, 1);

    // R6 direct mode
    code = 4'b1010; mode = 1'b1; wait_cyc(HOLD + 6);
    chk("R6 direct 10", step, 10);
    code = 4'b1111; wait_cyc(HOLD + 6);
    chk("R6 direct 15", step, 15);
    press_chk(3'b100, 15, 0, "R6 inc ignored in direct");
    press_chk(3'b001, 15, 0, "R6 centre ignored in direct");
    code = 4'b0000; wait_cyc(HOLD + 6);
    chk("R6 direct 0", step, 0);
    mode = 1'b0; wait_cyc(HOLD + 6);
    code = 4'b0111; wait_cyc(HOLD + 6);
    chk("R6 code ignored in counting", step, 0);
    press_chk(3'b010, 0, 0, "R4 dec at 0 after direct");
    press_chk(3'b100, 1, 1, "R2 inc after direct");

    // R8 power-down freeze
    c0 = nchg;
    pd = 1'b1; wait_cyc(2);
    press(3'b100);
    press(3'b001);
    chk("R8 frozen step", step, 1);
    chk("R8 frozen strobe", nchg - c0, 0);
    pd = 1'b0; wait_cyc(HOLD + 6);
    chk("R8 after wake", step, 1);
    press_chk(3'b100, 2, 1, "R8 resumes");

    // R1 mid-run reset
    rst = 1'b1; wait_cyc(1);
    chk("R1 mid-run reset", step, 8);
    rst = 1'b0; wait_cyc(2);
    chk("R9 strobe low idle", chg, 0);
    chk("R10 range", (step <= 16), 1);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule